// File: doc/BRIEF.md
# Soft-Output Hypothesis Tracker

This block sits behind a tree-search detector and receives, one per cycle, the candidate leaf results of one vector symbol. Each candidate carries a full label of `NUM_SYM` constellation symbols of `BITS_PER_SYM` bits each (24 bits with the defaults) and its complete Euclidean metric. The tracker keeps the label with the smallest metric seen so far as the best hypothesis. For every label bit it also keeps the smallest metric among the candidates that disagree with the best hypothesis on that bit. All of these per-bit slots are updated in parallel on every accepted candidate. When a new best arrives, the metric it displaces becomes the counter-hypothesis of each bit that flipped.

When the candidate flagged as last is accepted, the final state is captured and the working state returns to empty, so the next candidate starts a fresh symbol. Two cycles later the block presents the hard label, its metric and one signed, clipped soft value per bit, together with a single-cycle `out_valid`. The running best metric is exported on every cycle so that radius-pruning logic upstream can use it.

The input is a valid/ready stream. The block never applies back-pressure: `in_ready` is held high, and a source may present a candidate on every cycle, including directly after a last-of-symbol beat. The result port carries a plain valid strobe with no ready. A sink must take each result in the cycle it is shown. The all-ones metric code is reserved to mean "no candidate", so sources must send metrics below it.

Top module: `hyp_tracker`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and `cur_best_metric` is all ones.
- R2: The first accepted candidate of a symbol always becomes the best hypothesis, and `cur_best_metric` equals its metric on the next cycle.
- R3: A later candidate replaces the best only if its metric is strictly smaller. A candidate with an equal or larger metric leaves `cur_best_metric` unchanged.
- R4: When the best is replaced, every bit on which the old and new labels differ takes the old best metric as its counter-hypothesis metric.
- R5: A candidate that does not replace the best lowers the counter-hypothesis metric of each bit on which it differs from the best, and only when its metric is smaller than the stored value.
- R6: The soft value of bit k, at `out_llr[k*LLR_W +: LLR_W]` (two's complement), is (counter − best) when the best bit is 1 and (best − counter) when it is 0. Bit k is bit (k mod BITS_PER_SYM) of symbol (k / BITS_PER_SYM) in `in_bits`.
- R7: A bit with no counter-hypothesis (counter still all ones) gets +CLIP when its best bit is 1 and −CLIP when it is 0.
- R8: A soft value whose magnitude would exceed CLIP is limited to ±CLIP, with the sign of R6.
- R9: `out_valid` is high for exactly the one cycle two clock edges after the last-of-symbol beat is accepted. In that cycle `out_bits` and `out_metric` hold the final best label and metric.
- R10: A candidate accepted on the cycle right after a last-of-symbol beat starts a new symbol as in R2, and it does not disturb the result of the symbol that just ended.
- R11: Cycles with `in_valid` low change no state, whatever `in_bits`, `in_metric` and `in_last` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Candidate present |
| in_ready | output | 1 | Candidate accepted when high together with in_valid (always high) |
| in_bits | input | NUM_SYM*BITS_PER_SYM | Candidate label bits |
| in_metric | input | MET_W | Candidate Euclidean metric (all ones reserved) |
| in_last | input | 1 | Final candidate of the current symbol |
| cur_best_metric | output | MET_W | Running best metric of the symbol in progress |
| out_valid | output | 1 | One-cycle strobe: result fields valid |
| out_bits | output | NUM_SYM*BITS_PER_SYM | Hard decision label |
| out_metric | output | MET_W | Metric of the hard decision |
| out_llr | output | NUM_SYM*BITS_PER_SYM*LLR_W | Packed signed soft values, bit k in lane k |

## Verification
On every cycle the assertions check that the result strobe follows the accepted last beat by exactly two edges, and that a first candidate or a strictly better one takes over the running metric while a worse or equal one leaves it in place. They also check that no stored counter metric ever falls below the best metric, and that every presented soft value stays within ±CLIP. Some behaviours show only in the soft values the bench reads out at the end of its scenarios: which counter slot receives the displaced best metric, the keep-the-smaller rule, the exact value and sign of each soft value, and the separation of back-to-back symbols.

// File: rtl/ht_pkg.sv
package ht_pkg;

  // Per-lane update selected for one counter-hypothesis slot
  typedef enum logic [1:0] {
    UPD_KEEP          = 2'd0,
    UPD_TAKE_OLD_BEST = 2'd1,
    UPD_TAKE_CAND     = 2'd2
  } slot_op_e;

endpackage

// File: rtl/ht_best_reg.sv
module ht_best_reg #(
  parameter int NB    = 24,
  parameter int MET_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             restart,
  input  logic [NB-1:0]    cand_bits,
  input  logic [MET_W-1:0] cand_metric,
  output logic [NB-1:0]    best_bits,
  output logic [MET_W-1:0] best_metric,
  output logic             fresh,
  output logic             take,
  output logic [NB-1:0]    best_bits_nxt,
  output logic [MET_W-1:0] best_metric_nxt
);

  localparam logic [MET_W-1:0] MET_EMPTY = '1;

  // A candidate wins when the symbol is empty or it is strictly better
  always_comb begin
    take            = accept && (fresh || (cand_metric < best_metric));
    best_bits_nxt   = take ? cand_bits   : best_bits;
    best_metric_nxt = take ? cand_metric : best_metric;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      best_bits   <= '0;
      best_metric <= MET_EMPTY;
      fresh       <= 1'b1;
    end else if (accept) begin
      best_bits   <= best_bits_nxt;
      best_metric <= best_metric_nxt;
      fresh       <= 1'b0;
    end
  end

endmodule

// File: rtl/ht_cnt_slot.sv
module ht_cnt_slot
  import ht_pkg::*;
#(
  parameter int MET_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  slot_op_e         op,
  input  logic [MET_W-1:0] old_best,
  input  logic [MET_W-1:0] cand_metric,
  output logic [MET_W-1:0] cnt_q,
  output logic [MET_W-1:0] cnt_nxt
);

  localparam logic [MET_W-1:0] MET_EMPTY = '1;

  always_comb begin
    unique case (op)
      UPD_TAKE_OLD_BEST: cnt_nxt = old_best;
      UPD_TAKE_CAND:     cnt_nxt = (cand_metric < cnt_q) ? cand_metric : cnt_q;
      default:           cnt_nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= MET_EMPTY;
    else                   cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/ht_llr_lane.sv
module ht_llr_lane #(
  parameter int MET_W = 11,
  parameter int LLR_W = 7,
  parameter int CLIP  = 31
) (
  input  logic             best_bit,
  input  logic [MET_W-1:0] best_metric,
  input  logic [MET_W-1:0] cnt_metric,
  output logic [LLR_W-1:0] llr
);

  localparam logic [MET_W-1:0] CLIP_M = MET_W'(CLIP);
  localparam logic [LLR_W-1:0] CLIP_L = LLR_W'(CLIP);

  logic [MET_W-1:0] gap;
  logic             none;
  logic             sat;
  logic [LLR_W-1:0] mag;

  always_comb begin
    gap  = cnt_metric - best_metric;
    none = &cnt_metric;
    sat  = none || (gap > CLIP_M);
    mag  = sat ? CLIP_L : LLR_W'(gap);
    llr  = best_bit ? mag : (LLR_W'(0) - mag);
  end

endmodule

// File: rtl/hyp_tracker.sv
module hyp_tracker
  import ht_pkg::*;
#(
  parameter int NUM_SYM      = 4,
  parameter int BITS_PER_SYM = 6,
  parameter int MET_W        = 11,
  parameter int LLR_W        = 7,
  parameter int CLIP         = 31
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  output logic                                  in_ready,
  input  logic [NUM_SYM*BITS_PER_SYM-1:0]       in_bits,
  input  logic [MET_W-1:0]                      in_metric,
  input  logic                                  in_last,
  output logic [MET_W-1:0]                      cur_best_metric,
  output logic                                  out_valid,
  output logic [NUM_SYM*BITS_PER_SYM-1:0]       out_bits,
  output logic [MET_W-1:0]                      out_metric,
  output logic [NUM_SYM*BITS_PER_SYM*LLR_W-1:0] out_llr
);

  localparam int NB = NUM_SYM * BITS_PER_SYM;

  logic             accept;
  logic             sym_end;
  logic [NB-1:0]    a_q, a_nxt;
  logic [MET_W-1:0] da_q, da_nxt;
  logic             fresh;
  logic             better;

  logic [MET_W-1:0]    c_q   [NB];
  logic [MET_W-1:0]    c_nxt [NB];
  logic [NB*MET_W-1:0] c_flat;

  logic                snap_v;
  logic [NB-1:0]       snap_a;
  logic [MET_W-1:0]    snap_da;
  logic [MET_W-1:0]    snap_c [NB];
  logic [NB*LLR_W-1:0] llr_flat;

  assign in_ready        = 1'b1;
  assign accept          = in_valid && in_ready;
  assign sym_end         = accept && in_last;
  assign cur_best_metric = da_q;

  ht_best_reg #(.NB(NB), .MET_W(MET_W)) u_best (
    .clk             (clk),
    .rst_n           (rst_n),
    .accept          (accept),
    .restart         (sym_end),
    .cand_bits       (in_bits),
    .cand_metric     (in_metric),
    .best_bits       (a_q),
    .best_metric     (da_q),
    .fresh           (fresh),
    .take            (better),
    .best_bits_nxt   (a_nxt),
    .best_metric_nxt (da_nxt)
  );

  // One counter-hypothesis slot per label bit, all updated together
  for (genvar k = 0; k < NB; k++) begin : g_slot
    slot_op_e op;

    always_comb begin
      op = UPD_KEEP;
      if (accept && (a_q[k] ^ in_bits[k]))
        op = better ? UPD_TAKE_OLD_BEST : UPD_TAKE_CAND;
    end

    ht_cnt_slot #(.MET_W(MET_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (sym_end),
      .op          (op),
      .old_best    (da_q),
      .cand_metric (in_metric),
      .cnt_q       (c_q[k]),
      .cnt_nxt     (c_nxt[k])
    );

    assign c_flat[k*MET_W +: MET_W] = c_q[k];
  end

  // Capture the state the final candidate produces; working state restarts
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_v  <= 1'b0;
      snap_a  <= '0;
      snap_da <= '1;
    end else begin
      snap_v <= sym_end;
      if (sym_end) begin
        snap_a  <= a_nxt;
        snap_da <= da_nxt;
      end
    end
  end

  for (genvar k = 0; k < NB; k++) begin : g_snap
    always_ff @(posedge clk) begin
      if (!rst_n)       snap_c[k] <= '1;
      else if (sym_end) snap_c[k] <= c_nxt[k];
    end

    ht_llr_lane #(.MET_W(MET_W), .LLR_W(LLR_W), .CLIP(CLIP)) u_lane (
      .best_bit    (snap_a[k]),
      .best_metric (snap_da),
      .cnt_metric  (snap_c[k]),
      .llr         (llr_flat[k*LLR_W +: LLR_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_bits   <= '0;
      out_metric <= '0;
      out_llr    <= '0;
    end else begin
      out_valid <= snap_v;
      if (snap_v) begin
        out_bits   <= snap_a;
        out_metric <= snap_da;
        out_llr    <= llr_flat;
      end
    end
  end

endmodule

// File: rtl/ht_checker.sv
module ht_checker #(
  parameter int NB    = 24,
  parameter int MET_W = 11,
  parameter int LLR_W = 7,
  parameter int CLIP  = 31
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_last,
  input logic [MET_W-1:0]    in_metric,
  input logic [MET_W-1:0]    cur_best_metric,
  input logic                fresh,
  input logic [NB*MET_W-1:0] c_flat,
  input logic                out_valid,
  input logic [NB*LLR_W-1:0] out_llr
);

  logic end_d1, end_d2;
  logic cnt_ok, llr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      end_d1 <= 1'b0;
      end_d2 <= 1'b0;
    end else begin
      end_d1 <= in_valid && in_last;
      end_d2 <= end_d1;
    end
  end

  always_comb begin
    cnt_ok = 1'b1;
    for (int k = 0; k < NB; k++)
      if (c_flat[k*MET_W +: MET_W] < cur_best_metric) cnt_ok = 1'b0;
  end

  always_comb begin
    llr_ok = 1'b1;
    for (int k = 0; k < NB; k++) begin
      int v;
      v = int'($signed(out_llr[k*LLR_W +: LLR_W]));
      if (v > CLIP || v < -CLIP) llr_ok = 1'b0;
    end
  end

  a_r9_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == end_d2);

  a_r2_first_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fresh && !in_last) |=> (cur_best_metric == $past(in_metric)));

  a_r3_better_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_last && (in_metric < cur_best_metric)) |=>
      (cur_best_metric == $past(in_metric)));

  a_r3_worse_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fresh && !in_last && (in_metric >= cur_best_metric)) |=>
      $stable(cur_best_metric));

  a_r11_idle_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cur_best_metric));

  a_r5_cnt_not_below_best: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ok);

  a_r8_clip_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> llr_ok);

endmodule

bind hyp_tracker ht_checker #(
  .NB    (NUM_SYM*BITS_PER_SYM),
  .MET_W (MET_W),
  .LLR_W (LLR_W),
  .CLIP  (CLIP)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .in_last         (in_last),
  .in_metric       (in_metric),
  .cur_best_metric (cur_best_metric),
  .fresh           (fresh),
  .c_flat          (c_flat),
  .out_valid       (out_valid),
  .out_llr         (out_llr)
);

// File: tb/sim_hyp_tracker.sv
module sim_hyp_tracker;

  localparam int NS = 4, BPS = 6, MW = 11, LW = 7, CL = 31;
  localparam int NB = NS * BPS;
  localparam int MAXM = (1 << MW) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [NB-1:0]     in_bits = '0;
  logic [MW-1:0]     in_metric = '0;
  logic              in_last = 1'b0;
  logic [MW-1:0]     cur_best_metric;
  logic              out_valid;
  logic [NB-1:0]     out_bits;
  logic [MW-1:0]     out_metric;
  logic [NB*LW-1:0]  out_llr;

  int total = 0, bad = 0;

  // Reference state built from the requirements
  logic [NB-1:0] m_a;
  int            m_da;
  int            m_c [NB];
  bit            m_fresh;
  logic [NB-1:0] e_a;
  int            e_da;
  int            e_c [NB];

  always #5 clk = ~clk;

  hyp_tracker #(.NUM_SYM(NS), .BITS_PER_SYM(BPS), .MET_W(MW), .LLR_W(LW), .CLIP(CL)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bits(in_bits), .in_metric(in_metric), .in_last(in_last),
    .cur_best_metric(cur_best_metric), .out_valid(out_valid),
    .out_bits(out_bits), .out_metric(out_metric), .out_llr(out_llr)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lane(int k);
    return int'($signed(out_llr[k*LW +: LW]));
  endfunction

  function automatic int exp_llr(int k);
    int mag;
    if (e_c[k] == MAXM || e_c[k] - e_da > CL) mag = CL;
    else mag = e_c[k] - e_da;
    return e_a[k] ? mag : -mag;
  endfunction

  function automatic string lane_req(int k);
    if (e_c[k] == MAXM) return "R7";
    if (e_c[k] - e_da > CL) return "R8";
    return "R6";
  endfunction

  task automatic ref_reset();
    m_a = '0; m_da = MAXM; m_fresh = 1'b1;
    for (int k = 0; k < NB; k++) m_c[k] = MAXM;
  endtask

  task automatic ref_apply(logic [NB-1:0] b, int m);
    bit win;
    win = m_fresh || (m < m_da);
    for (int k = 0; k < NB; k++) begin
      if (m_a[k] != b[k]) begin
        if (win) m_c[k] = m_da;
        else if (m < m_c[k]) m_c[k] = m;
      end
    end
    if (win) begin m_a = b; m_da = m; end
    m_fresh = 1'b0;
  endtask

  // Called at a falling edge; returns at the next falling edge after acceptance
  task automatic send(logic [NB-1:0] b, int m, bit last);
    in_valid = 1'b1; in_bits = b; in_metric = MW'(m); in_last = last;
    @(negedge clk);
    ref_apply(b, m);
    if (last) begin
      e_a = m_a; e_da = m_da;
      for (int k = 0; k < NB; k++) e_c[k] = m_c[k];
      ref_reset();
    end
  endtask

  task automatic go_idle();
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic check_result(string tag);
    check({tag, " R9 out_valid"}, int'(out_valid), 1);
    check({tag, " R9 out_bits"}, int'(out_bits), int'(e_a));
    check({tag, " R9 out_metric"}, int'(out_metric), e_da);
    for (int k = 0; k < NB; k++)
      check($sformatf("%s %s lane%0d", tag, lane_req(k), k), lane(k), exp_llr(k));
  endtask

  // Called right after the last beat was accepted, with the input idle
  task automatic expect_done(string tag);
    check({tag, " R9 no early strobe"}, int'(out_valid), 0);
    @(negedge clk);
    check_result(tag);
    @(negedge clk);
    check({tag, " R9 single-cycle strobe"}, int'(out_valid), 0);
  endtask

  task automatic t_reset();
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 in_ready", int'(in_ready), 1);
    check("R1 cur_best_metric", int'(cur_best_metric), MAXM);
  endtask

  task automatic t_first_only();
    send(24'hA5A5A5, 300, 0);
    check("R2 first becomes best", int'(cur_best_metric), 300);
    send(24'hA5A5A5, 500, 1);
    go_idle();
    expect_done("single");
    for (int k = 0; k < NB; k++)
      check($sformatf("R7 unchallenged lane%0d", k), lane(k), 24'hA5A5A5 >> k & 1 ? CL : -CL);
  endtask

  task automatic t_replace();
    logic [NB-1:0] a, b;
    a = 24'h123456;
    b = a ^ 24'h000021;
    send(a, 50, 0);
    send(b, 40, 0);
    check("R3 better replaces", int'(cur_best_metric), 40);
    send(b ^ (24'h1 << 7), 45, 0);
    check("R3 worse kept", int'(cur_best_metric), 40);
    send(b ^ (24'h1 << 2), 40, 0);
    check("R3 equal not better", int'(cur_best_metric), 40);
    send(b, 60, 1);
    go_idle();
    expect_done("replace");
    check("R4 lane0 takes old best", lane(0), 10);
    check("R4 lane5 takes old best", lane(5), 10);
    check("R5 lane7 worse candidate", lane(7), -5);
    check("R6 lane2 equal metric gives zero", lane(2), 0);
  endtask

  task automatic t_keep_smaller();
    send(24'h000000, 20, 0);
    send(24'h1 << 9, 45, 0);
    send(24'h1 << 9, 48, 0);
    send(24'h1 << 9, 42, 1);
    go_idle();
    expect_done("smaller");
    check("R5 lane9 keeps smallest", lane(9), -22);
  endtask

  task automatic t_clip();
    send(24'hFFFFFF, 10, 0);
    send(24'hFFFFFF ^ (24'h1 << 3), 200, 1);
    go_idle();
    expect_done("clip");
    check("R8 lane3 clipped", lane(3), CL);
  endtask

  task automatic t_back_to_back();
    send(24'h0F0F0F, 77, 1);
    check("R10 state empty after last", int'(cur_best_metric), MAXM);
    send(24'hF0F0F0, 900, 0);
    check("R10 new symbol first best", int'(cur_best_metric), 900);
    check_result("b2b-first");
    send(24'hF0F0F0 ^ 24'h2, 950, 1);
    go_idle();
    expect_done("b2b-second");
    check("R10 lane1 second symbol", lane(1), -CL);
  endtask

  task automatic t_idle();
    send(24'h00FF00, 100, 0);
    in_valid = 1'b0; in_last = 1'b1; in_metric = 11'd1; in_bits = 24'hFFFFFF;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R11 idle no strobe", int'(out_valid), 0);
    end
    check("R11 idle keeps best", int'(cur_best_metric), 100);
    check("R11 ready held", int'(in_ready), 1);
    send(24'h00FF01, 130, 1);
    go_idle();
    expect_done("idle");
    check("R11 lane0 after idle", lane(0), -30);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    ref_reset();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_only();
    t_replace();
    t_keep_smaller();
    t_clip();
    t_back_to_back();
    t_idle();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule